// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is a station-management controller. It runs single read and write transactions to PHY registers over the two-wire management bus. A command carries a direction, a 5-bit PHY address, a 5-bit register address, 16 bits of write data and a flag that enables or skips the preamble. The command is taken on a valid/ready handshake. The block then derives the management clock (MDC) from the system clock and shifts the frame out on MDIO. It drives MDIO through an output value and an output enable, so an external tri-state pad can sit on the line. During a read it releases the line and captures the 16 bits that the PHY returns. Completion is signalled by a one-cycle done pulse, which carries the read data and a no-response flag.

The sequencer is a single state machine with six states:
- IDLE waits for a command.
- PRE shifts the optional preamble.
- HDR sends the start code, the opcode and both addresses.
- TA covers the two turnaround bits.
- DATA moves the 16-bit payload.
- GAP holds the line released for one full MDC cycle before the block becomes ready again.

Its transitions are:
- IDLE to PRE on an accepted command with preamble enabled.
- IDLE to HDR on an accepted command with preamble disabled.
- PRE to HDR after the last preamble bit is sampled.
- HDR to TA after the 14th header bit.
- TA to DATA after the second turnaround bit.
- DATA to GAP after the 16th data bit.
- GAP to IDLE on the falling MDC edge that closes the idle cycle.

A separate clock generator produces MDC and three strobes:
- rise, one cycle before MDC goes high;
- fall, one cycle before MDC goes low;
- drive, a fixed offset into each low phase.

Top module: `mgmt_frame_master`

## Requirements
- R1: After reset and whenever no frame is in progress: `mdc` is 0, `mdio_oe` is 0, `cmd_ready` is 1 and `done` is 0.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. From the next cycle, `cmd_ready` stays 0 until the frame and one idle MDC cycle have finished. Any `cmd_valid` during that time has no effect on the frame. `done` is a one-cycle pulse, and it comes in the same cycle that `cmd_ready` returns to 1.
- R3: The MDC high and low phases each last H system cycles, where H = max(`mdc_half`, MIN_HALF) as latched at acceptance. MIN_HALF defaults to 40, which gives at least 200 ns per phase at a 5 ns system clock.
- R4: With `cmd_preamble` = 1, the frame opens with 32 driven 1 bits. With `cmd_preamble` = 0, the first bit sampled is the start code.
- R5: The header is 14 driven bits, most significant bit first, in this order: start code 01, opcode (10 for read, 01 for write), PHY address [4:0], register address [4:0].
- R6: In a write, the turnaround bits are driven as 1 then 0. The 16 data bits from `cmd_wdata` follow, most significant bit first, all driven.
- R7: In a read, `mdio_oe` is 0 at the rising MDC edge of both turnaround bits and of all 16 data bits. The bits sampled from `mdio_i` at those data edges appear on `rdata`, most significant first, when `done` is 1.
- R8: In a read, `no_resp` is 1 with `done` if `mdio_i` was 1 at the second turnaround bit. Otherwise it is 0. A write leaves `no_resp` at 0.
- R9: `mdio_o` and `mdio_oe` change only while MDC is low, DRIVE_DLY+1 system cycles after a falling MDC edge. DRIVE_DLY defaults to 2.
- R10: After the last data bit, `mdio_oe` is 0 for one further rising MDC edge. A frame therefore has exactly 33 rising edges, or 65 with the preamble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_read | input | 1 | 1 = read, 0 = write |
| cmd_phy | input | 5 | PHY address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write payload |
| cmd_preamble | input | 1 | Send the 32-bit preamble |
| mdc_half | input | 8 | Requested MDC half period in system cycles |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven to the pad |
| mdio_oe | output | 1 | Pad output enable |
| mdio_i | input | 1 | Value read back from the pad |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result |
| no_resp | output | 1 | No PHY answered the read |

## Verification
Timing of each result:
- `cmd_ready` drops in the cycle after the accepting edge.
- Each MDIO bit change lands DRIVE_DLY+1 cycles after a falling MDC edge.
- MDC rises one cycle after the rise strobe.
- `done`, `rdata` and `no_resp` appear one cycle after the falling edge that ends the idle gap.

How the checks keep to that timing:
- The bench samples all ports on the falling system-clock edge.
- It records MDIO 1 ns after each rising MDC edge, which is where a PHY would latch it.
- It measures phase widths and drive offsets in whole system cycles. It compares them with H and DRIVE_DLY+2 as seen at a falling-edge sample.
- The PHY model changes `mdio_i` only at falling MDC edges, so read data is stable at every sampling point.

// File: rtl/mgmt_pkg.sv
`timescale 1ns/1ps
package mgmt_pkg;
    // Sequencer states, in frame order.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_DATA,
        ST_GAP
    } frame_state_t;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;
    localparam int HDR_W  = 4 + 2 * ADDR_W;   // start + opcode + two addresses

    localparam logic [1:0] START_CODE = 2'b01;
    localparam logic [1:0] OP_READ    = 2'b10;
    localparam logic [1:0] OP_WRITE   = 2'b01;
endpackage

// File: rtl/mgmt_mdc_gen.sv
`timescale 1ns/1ps
module mgmt_mdc_gen #(
    parameter int DIV_W     = 8,
    parameter int MIN_HALF  = 40,
    parameter int DRIVE_DLY = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_req,
    output logic             mdc,
    output logic             rise_en,
    output logic             fall_en,
    output logic             drive_en
);
    localparam logic [DIV_W-1:0] MIN_H   = DIV_W'(MIN_HALF);
    localparam logic [DIV_W-1:0] DRV_AT  = DIV_W'(DRIVE_DLY);
    localparam logic [DIV_W:0]   SEG_MIN = (DIV_W+1)'(MIN_HALF - 1);

    logic [DIV_W-1:0] half_eff;
    logic [DIV_W-1:0] cnt_q;
    logic             mdc_q;
    logic             last_q;

    // Enforce the minimum phase width regardless of the request.
    assign half_eff = (half_req < MIN_H) ? MIN_H : half_req;
    assign last_q   = (cnt_q == half_eff - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            mdc_q <= 1'b0;
        end else if (last_q) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign mdc      = mdc_q;
    assign rise_en  = run && !mdc_q && last_q;
    assign fall_en  = run &&  mdc_q && last_q;
    assign drive_en = run && !mdc_q && (cnt_q == DRV_AT);

    // Phase-length monitor guarding the minimum MDC width.
    logic [DIV_W:0] seg_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            seg_len_q <= '0;
        else if (mdc_q != (run && last_q ? ~mdc_q : mdc_q))
            seg_len_q <= '0;
        else if (seg_len_q != {(DIV_W+1){1'b1}})
            seg_len_q <= seg_len_q + 1'b1;
    end

    assert_mdc_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_q != $past(mdc_q)) |-> ($past(seg_len_q) >= SEG_MIN));
endmodule

// File: rtl/mgmt_frame_seq.sv
`timescale 1ns/1ps
module mgmt_frame_seq
    import mgmt_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int PRE_LEN = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic                  cmd_read,
    input  logic [ADDR_W-1:0]     cmd_phy,
    input  logic [ADDR_W-1:0]     cmd_reg,
    input  logic [DATA_W-1:0]     cmd_wdata,
    input  logic                  cmd_preamble,
    input  logic [DIV_W-1:0]      mdc_half,
    input  logic                  rise_en,
    input  logic                  fall_en,
    input  logic                  drive_en,
    output logic                  run,
    output logic [DIV_W-1:0]      half_q,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    input  logic                  mdio_i,
    output logic                  done,
    output logic [DATA_W-1:0]     rdata,
    output logic                  no_resp
);
    localparam int BITS_W   = $clog2(PRE_LEN);
    localparam int HDR_IDX  = $clog2(HDR_W);
    localparam int DATA_IDX = $clog2(DATA_W);

    frame_state_t         state_q, next_state;
    logic [BITS_W-1:0]    bits_q, load_bits;
    logic                 rd_q;
    logic [HDR_W-1:0]     hdr_q;
    logic [DATA_W-1:0]    wdata_q;
    logic                 accept;

    assign accept    = (state_q == ST_IDLE) && cmd_valid;
    assign cmd_ready = (state_q == ST_IDLE);
    assign run       = (state_q != ST_IDLE);

    always_comb begin
        next_state = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_valid) next_state = cmd_preamble ? ST_PRE : ST_HDR;
            ST_PRE:  if (rise_en && bits_q == '0) next_state = ST_HDR;
            ST_HDR:  if (rise_en && bits_q == '0) next_state = ST_TA;
            ST_TA:   if (rise_en && bits_q == '0) next_state = ST_DATA;
            ST_DATA: if (rise_en && bits_q == '0) next_state = ST_GAP;
            ST_GAP:  if (fall_en && bits_q == '0) next_state = ST_IDLE;
        endcase
    end

    always_comb begin
        load_bits = '0;
        unique case (next_state)
            ST_IDLE: load_bits = '0;
            ST_PRE:  load_bits = BITS_W'(PRE_LEN - 1);
            ST_HDR:  load_bits = BITS_W'(HDR_W - 1);
            ST_TA:   load_bits = BITS_W'(1);
            ST_DATA: load_bits = BITS_W'(DATA_W - 1);
            ST_GAP:  load_bits = BITS_W'(1);
        endcase
    end

    // State register and per-field bit counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bits_q  <= '0;
        end else begin
            state_q <= next_state;
            if (next_state != state_q)
                bits_q <= load_bits;
            else if (rise_en && bits_q != '0)
                bits_q <= bits_q - 1'b1;
        end
    end

    // Command capture, pad drive and read capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q    <= 1'b0;
            hdr_q   <= '0;
            wdata_q <= '0;
            half_q  <= '0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
            done    <= 1'b0;
            rdata   <= '0;
            no_resp <= 1'b0;
        end else begin
            done <= (state_q == ST_GAP) && (next_state == ST_IDLE);
            if (accept) begin
                rd_q    <= cmd_read;
                hdr_q   <= {START_CODE, (cmd_read ? OP_READ : OP_WRITE), cmd_phy, cmd_reg};
                wdata_q <= cmd_wdata;
                half_q  <= mdc_half;
                no_resp <= 1'b0;
            end
            if (drive_en) begin
                unique case (state_q)
                    ST_IDLE: mdio_oe <= 1'b0;
                    ST_PRE: begin
                        mdio_oe <= 1'b1;
                        mdio_o  <= 1'b1;
                    end
                    ST_HDR: begin
                        mdio_oe <= 1'b1;
                        mdio_o  <= hdr_q[bits_q[HDR_IDX-1:0]];
                    end
                    ST_TA: begin
                        mdio_oe <= !rd_q;
                        mdio_o  <= (bits_q == BITS_W'(1));
                    end
                    ST_DATA: begin
                        mdio_oe <= !rd_q;
                        mdio_o  <= wdata_q[bits_q[DATA_IDX-1:0]];
                    end
                    ST_GAP: mdio_oe <= 1'b0;
                endcase
            end
            if (rise_en && rd_q) begin
                if (state_q == ST_TA && bits_q == '0)
                    no_resp <= mdio_i;
                if (state_q == ST_DATA)
                    rdata <= {rdata[DATA_W-2:0], mdio_i};
            end
        end
    end

    assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !mdio_oe);

    assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_read_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_en && rd_q && (state_q == ST_TA || state_q == ST_DATA)) |-> !mdio_oe);

    assert_write_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_en && !rd_q && state_q != ST_GAP && state_q != ST_IDLE) |-> mdio_oe);
endmodule

// File: rtl/mgmt_frame_master.sv
`timescale 1ns/1ps
module mgmt_frame_master #(
    parameter int DIV_W     = 8,
    parameter int MIN_HALF  = 40,
    parameter int DRIVE_DLY = 2,
    parameter int PRE_LEN   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic             cmd_read,
    input  logic [4:0]       cmd_phy,
    input  logic [4:0]       cmd_reg,
    input  logic [15:0]      cmd_wdata,
    input  logic             cmd_preamble,
    input  logic [DIV_W-1:0] mdc_half,
    output logic             mdc,
    output logic             mdio_o,
    output logic             mdio_oe,
    input  logic             mdio_i,
    output logic             done,
    output logic [15:0]      rdata,
    output logic             no_resp
);
    logic             run;
    logic             rise_en, fall_en, drive_en;
    logic [DIV_W-1:0] half_q;

    mgmt_mdc_gen #(
        .DIV_W     (DIV_W),
        .MIN_HALF  (MIN_HALF),
        .DRIVE_DLY (DRIVE_DLY)
    ) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .half_req (half_q),
        .mdc      (mdc),
        .rise_en  (rise_en),
        .fall_en  (fall_en),
        .drive_en (drive_en)
    );

    mgmt_frame_seq #(
        .DIV_W   (DIV_W),
        .PRE_LEN (PRE_LEN)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_ready    (cmd_ready),
        .cmd_read     (cmd_read),
        .cmd_phy      (cmd_phy),
        .cmd_reg      (cmd_reg),
        .cmd_wdata    (cmd_wdata),
        .cmd_preamble (cmd_preamble),
        .mdc_half     (mdc_half),
        .rise_en      (rise_en),
        .fall_en      (fall_en),
        .drive_en     (drive_en),
        .run          (run),
        .half_q       (half_q),
        .mdio_o       (mdio_o),
        .mdio_oe      (mdio_oe),
        .mdio_i       (mdio_i),
        .done         (done),
        .rdata        (rdata),
        .no_resp      (no_resp)
    );

    // Pad outputs may only move while MDC is low.
    assert_change_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((mdio_oe != $past(mdio_oe)) || (mdio_o != $past(mdio_o))) |-> !mdc);
endmodule

// File: tb/test_mgmt_frame_master.sv
`timescale 1ns/1ps
module test_mgmt_frame_master;
    localparam int MIN_HALF  = 40;
    localparam int DRIVE_DLY = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_read = 1'b0;
    logic [4:0]  cmd_phy = '0;
    logic [4:0]  cmd_reg = '0;
    logic [15:0] cmd_wdata = '0;
    logic        cmd_preamble = 1'b0;
    logic [7:0]  mdc_half = '0;
    logic        mdc, mdio_o, mdio_oe, mdio_i, done, no_resp;
    logic [15:0] rdata;
    logic        phy_val = 1'b1;

    always #2.5 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : phy_val;

    mgmt_frame_master i_mgmt_frame_master (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_read(cmd_read), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
        .cmd_wdata(cmd_wdata), .cmd_preamble(cmd_preamble), .mdc_half(mdc_half),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
        .done(done), .rdata(rdata), .no_resp(no_resp)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk_eq(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Frame recorder: pad state at each rising MDC edge.
    logic        rec_oe [0:79];
    logic        rec_v  [0:79];
    int          edge_n = 0;
    int          rsp_off = 0;
    logic        rsp_ta2 = 1'b0;
    logic [15:0] rsp_data = '0;

    always @(posedge mdc) begin
        #1;
        if (edge_n < 80) begin
            rec_oe[edge_n] = mdio_oe;
            rec_v[edge_n]  = mdio_o;
        end
        edge_n++;
    end

    // PHY model: present the next bit after each falling MDC edge.
    always @(negedge mdc) begin
        int p;
        p = edge_n - rsp_off;
        if (p == 15)
            phy_val = rsp_ta2;
        else if (p >= 16 && p <= 31)
            phy_val = rsp_data[31-p];
        else
            phy_val = 1'b1;
    end

    // Timing monitor, sampled on the falling system-clock edge.
    int   hi_len = 0, hi_min = 0, hi_max = 0;
    int   per_min = 0, per_max = 0;
    longint cyc = 0, last_rise = 0;
    int   since_fall = 0;
    bit   seen_fall = 0;
    int   bad_drive = 0;
    logic prev_mdc = 1'b0, prev_oe = 1'b0, prev_o = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (mdc && !prev_mdc) begin
            hi_len = 1;
            if (last_rise != 0) begin
                if (int'(cyc - last_rise) < per_min) per_min = int'(cyc - last_rise);
                if (int'(cyc - last_rise) > per_max) per_max = int'(cyc - last_rise);
            end
            last_rise = cyc;
        end else if (mdc) begin
            hi_len++;
        end
        if (!mdc && prev_mdc) begin
            if (hi_len < hi_min) hi_min = hi_len;
            if (hi_len > hi_max) hi_max = hi_len;
            since_fall = 1;
            seen_fall  = 1;
        end else begin
            since_fall++;
        end
        if ((mdio_oe != prev_oe) || (mdio_oe && mdio_o != prev_o)) begin
            if (mdc || (seen_fall && since_fall != DRIVE_DLY + 2))
                bad_drive++;
        end
        prev_mdc = mdc;
        prev_oe  = mdio_oe;
        prev_o   = mdio_o;
    end

    task automatic run_frame(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                             input logic [15:0] wd, input bit pre, input int half,
                             input bit ta2, input logic [15:0] rsp, input bit poke);
        int off, eff, e, n;
        logic [13:0] hdr;
        off = pre ? 32 : 0;
        eff = (half < MIN_HALF) ? MIN_HALF : half;
        hdr = {2'b01, (rd ? 2'b10 : 2'b01), phy, rg};
        @(negedge clk);
        edge_n = 0; rsp_off = off; rsp_ta2 = ta2; rsp_data = rsp;
        hi_min = 1 << 20; hi_max = 0; per_min = 1 << 20; per_max = 0;
        last_rise = 0; seen_fall = 0; bad_drive = 0;
        cmd_read = rd; cmd_phy = phy; cmd_reg = rg; cmd_wdata = wd;
        cmd_preamble = pre; mdc_half = 8'(half); cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk_eq("R2", "ready low after accept", cmd_ready, 0);
        if (poke) begin
            // A second command offered mid-frame must not disturb the frame.
            repeat (100) @(negedge clk);
            cmd_read = ~rd; cmd_phy = ~phy; cmd_reg = ~rg; cmd_wdata = ~wd;
            cmd_preamble = ~pre; cmd_valid = 1'b1;
            repeat (50) @(negedge clk);
            chk_eq("R2", "ready low while busy", cmd_ready, 0);
            cmd_valid = 1'b0;
        end
        n = 0;
        while (done !== 1'b1 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk_eq("R2", "done before timeout", (n < 20000), 1);
        chk_eq("R2", "ready with done", cmd_ready, 1);
        chk_eq("R10", "rising edges per frame", edge_n, off + 33);
        e = 0;
        for (int i = 0; i < off; i++)
            if (!(rec_oe[i] === 1'b1 && rec_v[i] === 1'b1)) e++;
        chk_eq("R4", "preamble bit errors", e, 0);
        e = 0;
        for (int i = 0; i < 14; i++)
            if (!(rec_oe[off+i] === 1'b1 && rec_v[off+i] === hdr[13-i])) e++;
        chk_eq("R5", "header bit errors", e, 0);
        e = 0;
        if (rd) begin
            if (rec_oe[off+14] !== 1'b0 || rec_oe[off+15] !== 1'b0) e++;
            for (int i = 0; i < 16; i++)
                if (rec_oe[off+16+i] !== 1'b0) e++;
            chk_eq("R7", "read release errors", e, 0);
            chk_eq("R7", "read data", rdata, ta2 ? 16'hFFFF : rsp);
            chk_eq("R8", "no_resp flag", no_resp, ta2);
        end else begin
            if (!(rec_oe[off+14] === 1'b1 && rec_v[off+14] === 1'b1)) e++;
            if (!(rec_oe[off+15] === 1'b1 && rec_v[off+15] === 1'b0)) e++;
            for (int i = 0; i < 16; i++)
                if (!(rec_oe[off+16+i] === 1'b1 && rec_v[off+16+i] === wd[15-i])) e++;
            chk_eq("R6", "write turnaround and data errors", e, 0);
            chk_eq("R8", "no_resp after write", no_resp, 0);
        end
        chk_eq("R10", "gap edge released", rec_oe[off+32], 0);
        chk_eq("R3", "MDC high min", hi_min, eff);
        chk_eq("R3", "MDC high max", hi_max, eff);
        chk_eq("R3", "MDC period min", per_min, 2 * eff);
        chk_eq("R3", "MDC period max", per_max, 2 * eff);
        chk_eq("R9", "drive timing violations", bad_drive, 0);
        @(negedge clk);
        chk_eq("R2", "done single cycle", done, 0);
        chk_eq("R1", "released between frames", {mdc, mdio_oe}, 0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk_eq("R1", "mdc after reset", mdc, 0);
        chk_eq("R1", "oe after reset", mdio_oe, 0);
        chk_eq("R1", "ready after reset", cmd_ready, 1);
        chk_eq("R1", "done after reset", done, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        run_frame(1'b0, 5'h1A, 5'h03, 16'hA5C3, 1'b1,  0, 1'b0, 16'h0000, 1'b0);
        run_frame(1'b1, 5'h05, 5'h1F, 16'h0000, 1'b0, 60, 1'b0, 16'h3C96, 1'b0);
        run_frame(1'b1, 5'h11, 5'h00, 16'h0000, 1'b1, 39, 1'b1, 16'hFFFF, 1'b0);
        run_frame(1'b0, 5'h00, 5'h15, 16'h0001, 1'b0, 41, 1'b0, 16'h0000, 1'b1);
        run_frame(1'b1, 5'h1F, 5'h0A, 16'h0000, 1'b1, 40, 1'b0, 16'h8000, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(150000 * 5);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule